// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that does not drive its own bus strobes. Instead, the processor presents a three-bit status code on every clock. The block samples that code on each rising edge and detects the start of a bus cycle: a cycle starts when the code moves away from the passive value. It then produces the address latch strobe, the read and write commands for memory and I/O space, and the interrupt acknowledge strobe. It also produces the data buffer enable, the transfer direction, and a dual-purpose enable output. Every output comes from the status code, the clock and two strap inputs.

Each cycle has two phases. The first clock after a start is the address phase, and the address latch strobe is high only then. The remaining clocks, up to the sample that shows the passive code again, form the data phase. Normal read and write commands are high in the data phase. The early ("advanced") write commands also cover the address phase, so they rise one clock before the normal writes.

A command-enable strap gates the commands off. A mode strap picks the meaning of the dual-purpose output: either a cascade enable for an interrupt controller, or a copy of the data enable for a peripheral bus. All outputs are active high.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and until a cycle starts after it, every output is low.
- R2: A cycle starts at the first rising edge that samples `status` different from 3'b111 while no cycle is open. `ale` is high for exactly the one clock that follows that edge.
- R3: Read commands follow the status code: 3'b101 (memory read) and 3'b100 (code fetch) raise `mem_rd`, and 3'b001 raises `io_rd`. They are high from the second clock of the cycle until the cycle ends, and at most one of the five normal strobes is high at a time.
- R4: Write commands follow the status code: 3'b110 raises `mem_wr` and 3'b010 raises `io_wr` from the second clock of the cycle. `mem_wr_adv` and `io_wr_adv` rise one clock earlier, in the first clock, and fall together with the normal write.
- R5: The edge that samples `status` == 3'b111 closes the cycle. Every command and `den` are low in the clock that follows.
- R6: A change of `status` from one non-passive code to another does not start a new cycle. `ale` stays low and the cycle type latched at the start is kept.
- R7: The halt code 3'b011 produces the `ale` pulse but no command strobe and no `den`.
- R8: The code 3'b000 is an acknowledge cycle, and `int_ack` is high in its data phase. Two acknowledge cycles separated by a passive sample give exactly two separate `int_ack` pulses.
- R9: While `cmd_en` is low, all seven command outputs, `den` and `mce_pden` are low in that same clock. `ale` and `dt_r` are not affected.
- R10: With `iob_mode` low, `mce_pden` is high in the first clock of an acknowledge cycle (cascade enable). With `iob_mode` high, `mce_pden` equals `den` (peripheral data enable).
- R11: `den` is high in the data phase of every cycle type except halt. `dt_r` is high through both phases of a write cycle (3'b110, 3'b010) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; status sampled on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 3 | Processor status code, 3'b111 = passive |
| cmd_en | input | 1 | Command enable strap; low suppresses commands |
| iob_mode | input | 1 | Selects meaning of `mce_pden` |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_wr_adv | output | 1 | Early memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| io_wr_adv | output | 1 | Early I/O write command |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Data buffer enable |
| dt_r | output | 1 | Direction: 1 = toward bus (write), 0 = receive |
| mce_pden | output | 1 | Cascade enable or peripheral data enable |

## Verification
Three pairs of functions can land in the same clock. The end of one cycle can fall in the clock where the next might start: the bench drives the passive code for exactly one sample between two acknowledge cycles and counts the separate `int_ack` pulses. The command-enable strap can drop in the middle of a write's data phase: the bench checks that the strobes vanish in that same clock while `dt_r` and `ale` stay as the cycle dictates. The mode strap can change between acknowledge cycles: the bench judges `mce_pden` against the first-clock rule in one mode and against `den` in the other.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    localparam int STATUS_W = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_ACK     = 3'b000,
        ST_IO_RD   = 3'b001,
        ST_IO_WR   = 3'b010,
        ST_HALT    = 3'b011,
        ST_FETCH   = 3'b100,
        ST_MEM_RD  = 3'b101,
        ST_MEM_WR  = 3'b110,
        ST_PASSIVE = 3'b111
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA
    } phase_e;

    typedef enum logic [2:0] {
        CY_NONE,
        CY_ACK,
        CY_IO_RD,
        CY_IO_WR,
        CY_MEM_RD,
        CY_MEM_WR,
        CY_HALT
    } cycle_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic mem_wr_adv;
        logic io_rd;
        logic io_wr;
        logic io_wr_adv;
        logic int_ack;
    } cmd_t;

    typedef struct packed {
        logic ale;
        logic den;
        logic dt_r;
        logic mce_pden;
    } ctl_t;

    function automatic cycle_e classify(input logic [STATUS_W-1:0] code);
        cycle_e kind;
        case (status_e'(code))
            ST_ACK:    kind = CY_ACK;
            ST_IO_RD:  kind = CY_IO_RD;
            ST_IO_WR:  kind = CY_IO_WR;
            ST_HALT:   kind = CY_HALT;
            ST_FETCH:  kind = CY_MEM_RD;
            ST_MEM_RD: kind = CY_MEM_RD;
            ST_MEM_WR: kind = CY_MEM_WR;
            default:   kind = CY_NONE;
        endcase
        return kind;
    endfunction

    function automatic logic is_write(input cycle_e kind);
        return (kind == CY_MEM_WR) || (kind == CY_IO_WR);
    endfunction

    function automatic logic is_transfer(input cycle_e kind);
        return (kind != CY_NONE) && (kind != CY_HALT);
    endfunction

endpackage

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
    import bus_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] status,
    output phase_e              phase,
    output cycle_e              cycle
);

    logic passive;
    assign passive = (status_e'(status) == ST_PASSIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cycle <= CY_NONE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!passive) begin
                        phase <= PH_ADDR;
                        cycle <= classify(status);
                    end
                end
                PH_ADDR: begin
                    if (passive) begin
                        phase <= PH_IDLE;
                        cycle <= CY_NONE;
                    end else begin
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (passive) begin
                        phase <= PH_IDLE;
                        cycle <= CY_NONE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cycle <= CY_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
    import bus_cmd_pkg::*;
(
    input  phase_e phase,
    input  cycle_e cycle,
    input  logic   cmd_en,
    output cmd_t   cmd
);

    logic in_addr;
    logic in_data;
    logic open_cyc;

    assign in_addr  = (phase == PH_ADDR);
    assign in_data  = (phase == PH_DATA);
    assign open_cyc = in_addr || in_data;

    always_comb begin
        cmd = '0;
        if (cmd_en) begin
            cmd.mem_rd     = in_data  && (cycle == CY_MEM_RD);
            cmd.mem_wr     = in_data  && (cycle == CY_MEM_WR);
            cmd.mem_wr_adv = open_cyc && (cycle == CY_MEM_WR);
            cmd.io_rd      = in_data  && (cycle == CY_IO_RD);
            cmd.io_wr      = in_data  && (cycle == CY_IO_WR);
            cmd.io_wr_adv  = open_cyc && (cycle == CY_IO_WR);
            cmd.int_ack    = in_data  && (cycle == CY_ACK);
        end
    end

endmodule

// File: rtl/bus_ctl_gen.sv
module bus_ctl_gen
    import bus_cmd_pkg::*;
(
    input  phase_e phase,
    input  cycle_e cycle,
    input  logic   cmd_en,
    input  logic   iob_mode,
    output ctl_t   ctl
);

    logic in_addr;
    logic in_data;
    logic data_en;
    logic cascade_en;

    assign in_addr    = (phase == PH_ADDR);
    assign in_data    = (phase == PH_DATA);
    assign data_en    = cmd_en && in_data && is_transfer(cycle);
    assign cascade_en = cmd_en && in_addr && (cycle == CY_ACK);

    always_comb begin
        ctl.ale      = in_addr;
        ctl.den      = data_en;
        ctl.dt_r     = (in_addr || in_data) && is_write(cycle);
        ctl.mce_pden = iob_mode ? data_en : cascade_en;
    end

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bus_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] status,
    input  logic                cmd_en,
    input  logic                iob_mode,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                mem_wr_adv,
    output logic                io_rd,
    output logic                io_wr,
    output logic                io_wr_adv,
    output logic                int_ack,
    output logic                ale,
    output logic                den,
    output logic                dt_r,
    output logic                mce_pden
);

    phase_e phase;
    cycle_e cycle;
    cmd_t   cmd;
    ctl_t   ctl;

    bus_cycle_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .phase  (phase),
        .cycle  (cycle)
    );

    bus_cmd_decode u_cmd (
        .phase  (phase),
        .cycle  (cycle),
        .cmd_en (cmd_en),
        .cmd    (cmd)
    );

    bus_ctl_gen u_ctl (
        .phase    (phase),
        .cycle    (cycle),
        .cmd_en   (cmd_en),
        .iob_mode (iob_mode),
        .ctl      (ctl)
    );

    assign mem_rd     = cmd.mem_rd;
    assign mem_wr     = cmd.mem_wr;
    assign mem_wr_adv = cmd.mem_wr_adv;
    assign io_rd      = cmd.io_rd;
    assign io_wr      = cmd.io_wr;
    assign io_wr_adv  = cmd.io_wr_adv;
    assign int_ack    = cmd.int_ack;
    assign ale        = ctl.ale;
    assign den        = ctl.den;
    assign dt_r       = ctl.dt_r;
    assign mce_pden   = ctl.mce_pden;

endmodule

// File: rtl/bus_cmd_gen_chk.sv
module bus_cmd_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] status,
    input logic       cmd_en,
    input logic       iob_mode,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_wr_adv,
    input logic       io_rd,
    input logic       io_wr,
    input logic       io_wr_adv,
    input logic       int_ack,
    input logic       ale,
    input logic       den,
    input logic       dt_r,
    input logic       mce_pden
);

    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));

    p_adv_leads_mem_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr) && $past(cmd_en)) |-> $past(mem_wr_adv));

    p_adv_leads_io_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(io_wr) && $past(cmd_en)) |-> $past(io_wr_adv));

    p_close_on_passive_r5: assert property (@(posedge clk) disable iff (rst)
        (status == 3'b111) |=> !(mem_rd || mem_wr || mem_wr_adv || io_rd ||
                                 io_wr || io_wr_adv || int_ack || den));

    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd_en |-> !(mem_rd || mem_wr || mem_wr_adv || io_rd || io_wr ||
                      io_wr_adv || int_ack || den || mce_pden));

    p_pden_follows_den_r10: assert property (@(posedge clk) disable iff (rst)
        iob_mode |-> (mce_pden == den));

endmodule

bind bus_cmd_gen bus_cmd_gen_chk u_chk (.*);

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] status = 3'b111;
    logic       cmd_en = 1'b1;
    logic       iob_mode = 1'b0;
    logic mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv;
    logic int_ack, ale, den, dt_r, mce_pden;

    always #10 clk = ~clk;

    bus_cmd_gen u_dut (
        .clk(clk), .rst(rst), .status(status), .cmd_en(cmd_en),
        .iob_mode(iob_mode), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wr_adv(mem_wr_adv), .io_rd(io_rd), .io_wr(io_wr),
        .io_wr_adv(io_wr_adv), .int_ack(int_ack), .ale(ale), .den(den),
        .dt_r(dt_r), .mce_pden(mce_pden)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string scene = "R1";
    int    ack_rises = 0;
    bit    last_ack = 0;

    // behavioural reference: clocks since cycle start, and the code that opened it
    int m_age  = -1;
    int m_kind = 7;

    always @(posedge clk) begin
        if (rst) begin
            m_age  = -1;
            m_kind = 7;
        end else if (status == 3'b111) begin
            m_age = -1;
        end else if (m_age < 0) begin
            m_age  = 0;
            m_kind = int'(status);
        end else begin
            m_age = m_age + 1;
        end
    end

    task automatic check(input string tag, input string name, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s/%s %s actual=%0b expected=%0b at %0t", tag, scene, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit first, later, wr, xfer, e_den;
        first = (m_age == 0);
        later = (m_age >= 1);
        wr    = (m_kind == 6) || (m_kind == 2);
        xfer  = (m_kind != 3);
        e_den = cmd_en && later && xfer;
        check("R3",  "mem_rd",     mem_rd,     cmd_en && later && (m_kind == 5 || m_kind == 4));
        check("R3",  "io_rd",      io_rd,      cmd_en && later && m_kind == 1);
        check("R4",  "mem_wr",     mem_wr,     cmd_en && later && m_kind == 6);
        check("R4",  "io_wr",      io_wr,      cmd_en && later && m_kind == 2);
        check("R4",  "mem_wr_adv", mem_wr_adv, cmd_en && (first || later) && m_kind == 6);
        check("R4",  "io_wr_adv",  io_wr_adv,  cmd_en && (first || later) && m_kind == 2);
        check("R8",  "int_ack",    int_ack,    cmd_en && later && m_kind == 0);
        check("R2",  "ale",        ale,        first);
        check("R11", "den",        den,        e_den);
        check("R11", "dt_r",       dt_r,       (first || later) && wr);
        check("R10", "mce_pden",   mce_pden,   iob_mode ? e_den : (cmd_en && first && m_kind == 0));
        if (int_ack && !last_ack) ack_rises++;
        last_ack = int_ack;
    endtask

    task automatic step(input logic [2:0] code, input logic en);
        @(negedge clk);
        compare_all();
        status = code;
        cmd_en = en;
    endtask

    task automatic bus_cycle(input logic [2:0] code, input int len);
        for (int i = 0; i < len; i++) step(code, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        scene = "R1";
        status = 3'b101;          // ignored while reset is held
        repeat (3) step(3'b101, 1'b1);
        @(negedge clk);
        compare_all();
        check("R1", "all_low", |{mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr,
                                 io_wr_adv, int_ack, ale, den, dt_r, mce_pden}, 1'b0);
        status = 3'b111;
        rst = 1'b0;
        step(3'b111, 1'b1);

        scene = "R3";
        bus_cycle(3'b101, 4);
        bus_cycle(3'b100, 3);
        bus_cycle(3'b001, 3);

        scene = "R4";
        bus_cycle(3'b110, 4);
        bus_cycle(3'b010, 3);

        scene = "R2";   // one-clock cycle: ALE only
        bus_cycle(3'b101, 1);

        scene = "R7";
        bus_cycle(3'b011, 4);

        scene = "R6";   // non-passive to non-passive: same cycle
        step(3'b101, 1'b1);
        step(3'b101, 1'b1);
        step(3'b110, 1'b1);
        step(3'b110, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);

        scene = "R8";   // two acknowledge cycles, one passive sample between
        ack_rises = 0;
        iob_mode = 1'b0;
        step(3'b000, 1'b1);
        step(3'b000, 1'b1);
        step(3'b111, 1'b1);
        step(3'b000, 1'b1);
        step(3'b000, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
        checks++;
        if (ack_rises != 2) begin
            errors++;
            $display("FAIL R8 ack pulses actual=%0d expected=2", ack_rises);
        end

        scene = "R9";   // enable drops mid write
        step(3'b110, 1'b1);
        step(3'b110, 1'b1);
        step(3'b110, 1'b0);
        step(3'b110, 1'b0);
        step(3'b110, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
        step(3'b000, 1'b0);   // acknowledge with enable low: no cascade enable
        step(3'b000, 1'b0);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);

        scene = "R10";
        iob_mode = 1'b1;
        bus_cycle(3'b001, 3);
        bus_cycle(3'b000, 3);
        iob_mode = 1'b0;
        bus_cycle(3'b000, 3);

        scene = "R5";   // back-to-back read then write
        step(3'b101, 1'b1);
        step(3'b101, 1'b1);
        step(3'b111, 1'b1);
        step(3'b010, 1'b1);
        step(3'b010, 1'b1);
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);

        scene = "R11";
        bus_cycle(3'b110, 2);
        bus_cycle(3'b100, 2);

        finish_run();
    end

endmodule